// File: doc/BRIEF.md
# Register-Resident Page Map Translator

This block translates every 16-bit logical address into an 18-bit physical address through a page table held entirely in eight flip-flop entries inside the block. The upper three address bits pick an entry. That entry supplies a 5-bit frame number, and the frame number is placed above the untouched 13-bit in-page offset. Pages are 8 KB. Translation is purely combinational, so the physical address, the forwarded access strobe and the fault line are valid in the same cycle as the logical address.

Each entry holds a frame number and a valid bit. An access that lands on an invalid entry raises the fault output and does not forward the access strobe. The table can be changed only while the privilege input is high. Supervisor code can rewrite single entries, or it can clear every valid bit in one cycle and then reload the entries when a new process is dispatched. An update attempted without privilege has no effect on the table and latches a sticky violation flag. Only reset clears that flag.

Top module: `page_map_xlate`

## Requirements
- R1: `pa_o[12:0]` always equals `vaddr_i[12:0]` in the same cycle.
- R2: `pa_o[17:13]` equals the frame number stored in entry `vaddr_i[15:13]` in the same cycle. This holds whether the entry is valid or not.
- R3: After reset every entry is invalid with frame 0, and `priv_viol_o` is 0.
- R4: When `wr_en_i` and `priv_i` are both high at a clock edge, entry `wr_idx_i` takes `wr_frame_i` and `wr_valid_i`. Translation in the same cycle still uses the old contents, and the new contents are used from the next cycle.
- R5: An entry write with `priv_i` low leaves the table unchanged.
- R6: When `wr_en_i` or `flush_i` is high with `priv_i` low at a clock edge, `priv_viol_o` becomes 1. It stays 1 until `rst_ni` is asserted.
- R7: When `req_i` is 1 and the selected entry is valid, `acc_o` is 1 and `fault_o` is 0.
- R8: When `req_i` is 1 and the selected entry is invalid, `fault_o` is 1 and `acc_o` is 0. When `req_i` is 0, both outputs are 0.
- R9: When `flush_i` and `priv_i` are high at a clock edge, all valid bits clear. If a privileged entry write happens in the same cycle, the written entry takes the written values.
- R10: A `flush_i` with `priv_i` low leaves every valid bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe from the CPU |
| vaddr_i | input | 16 | Logical address |
| pa_o | output | 18 | Physical address: frame followed by offset |
| acc_o | output | 1 | Forwarded access strobe, valid entry only |
| fault_o | output | 1 | Access reached an invalid entry |
| priv_i | input | 1 | Supervisor mode indicator |
| wr_en_i | input | 1 | Entry write request |
| wr_idx_i | input | 3 | Entry to write |
| wr_frame_i | input | 5 | Frame number to store |
| wr_valid_i | input | 1 | Valid bit to store |
| flush_i | input | 1 | Clear all valid bits |
| priv_viol_o | output | 1 | Sticky flag for a rejected unprivileged update |

## Verification
A table update and a translation of the same entry can occur in one cycle. The bench writes entry 2 while the logical address points into page 2. It expects the old frame during that cycle and the new frame in the next. A flush and an entry write can also coincide. The bench issues both at one edge and then judges the result by the strobes: pages that were not written must fault, and the written page must forward the access with its new frame.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int unsigned VA_W_DEF    = 16;
  localparam int unsigned OFF_W_DEF   = 13;
  localparam int unsigned FRAME_W_DEF = 5;

  typedef enum logic [1:0] {
    UPD_NONE  = 2'b00,
    UPD_WRITE = 2'b01,
    UPD_FLUSH = 2'b10,
    UPD_BOTH  = 2'b11
  } upd_e;
endpackage

// File: rtl/pmt_priv_gate.sv
module pmt_priv_gate
  import pmt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic priv_i,
  input  logic wr_en_i,
  input  logic flush_i,
  output upd_e upd_o,
  output logic viol_o
);
  logic viol_q;

  always_comb begin
    upd_o = UPD_NONE;
    if (priv_i) upd_o = upd_e'({flush_i, wr_en_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             viol_q <= 1'b0;
    else if (!priv_i && (wr_en_i || flush_i)) viol_q <= 1'b1;
  end

  assign viol_o = viol_q;
endmodule

// File: rtl/pmt_entry_bank.sv
module pmt_entry_bank
  import pmt_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned FRAME_W = 5,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  upd_e                       upd_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [FRAME_W-1:0]         wr_frame_i,
  input  logic                       wr_valid_i,
  output logic [ENTRIES*FRAME_W-1:0] frames_o,
  output logic [ENTRIES-1:0]         valid_o
);
  logic do_wr, do_flush;
  assign do_wr    = (upd_i == UPD_WRITE) || (upd_i == UPD_BOTH);
  assign do_flush = (upd_i == UPD_FLUSH) || (upd_i == UPD_BOTH);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [FRAME_W-1:0] frame_q;
    logic               valid_q;
    logic               hit;
    assign hit = do_wr && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q <= '0;
        valid_q <= 1'b0;
      end else if (hit) begin
        // write outranks a concurrent flush on its own entry
        frame_q <= wr_frame_i;
        valid_q <= wr_valid_i;
      end else if (do_flush) begin
        valid_q <= 1'b0;
      end
    end

    assign frames_o[g*FRAME_W +: FRAME_W] = frame_q;
    assign valid_o[g]                     = valid_q;
  end
endmodule

// File: rtl/pmt_xlate.sv
module pmt_xlate #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned FRAME_W = 5,
  parameter int unsigned OFF_W   = 13,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic                       req_i,
  input  logic [IDX_W-1:0]           page_i,
  input  logic [OFF_W-1:0]           off_i,
  input  logic [ENTRIES*FRAME_W-1:0] frames_i,
  input  logic [ENTRIES-1:0]         valid_i,
  output logic [PA_W-1:0]            pa_o,
  output logic                       acc_o,
  output logic                       fault_o
);
  logic [FRAME_W-1:0] frame_sel;
  logic               valid_sel;

  always_comb begin
    frame_sel = '0;
    valid_sel = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (page_i == IDX_W'(i)) begin
        frame_sel = frames_i[i*FRAME_W +: FRAME_W];
        valid_sel = valid_i[i];
      end
    end
  end

  assign pa_o    = {frame_sel, off_i};
  assign acc_o   = req_i && valid_sel;
  assign fault_o = req_i && !valid_sel;
endmodule

// File: rtl/page_map_xlate.sv
module page_map_xlate
  import pmt_pkg::*;
#(
  parameter int unsigned VA_W    = VA_W_DEF,
  parameter int unsigned OFF_W   = OFF_W_DEF,
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  localparam int unsigned IDX_W   = VA_W - OFF_W,
  localparam int unsigned ENTRIES = 1 << IDX_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [VA_W-1:0]    vaddr_i,
  output logic [PA_W-1:0]    pa_o,
  output logic               acc_o,
  output logic               fault_o,
  input  logic               priv_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [FRAME_W-1:0] wr_frame_i,
  input  logic               wr_valid_i,
  input  logic               flush_i,
  output logic               priv_viol_o
);
  upd_e                       upd;
  logic [ENTRIES*FRAME_W-1:0] frames;
  logic [ENTRIES-1:0]         valid;

  pmt_priv_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .priv_i  (priv_i),
    .wr_en_i (wr_en_i),
    .flush_i (flush_i),
    .upd_o   (upd),
    .viol_o  (priv_viol_o)
  );

  pmt_entry_bank #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (upd),
    .wr_idx_i   (wr_idx_i),
    .wr_frame_i (wr_frame_i),
    .wr_valid_i (wr_valid_i),
    .frames_o   (frames),
    .valid_o    (valid)
  );

  pmt_xlate #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_xlate (
    .req_i    (req_i),
    .page_i   (vaddr_i[VA_W-1:OFF_W]),
    .off_i    (vaddr_i[OFF_W-1:0]),
    .frames_i (frames),
    .valid_i  (valid),
    .pa_o     (pa_o),
    .acc_o    (acc_o),
    .fault_o  (fault_o)
  );
endmodule

// File: rtl/page_map_xlate_chk.sv
module page_map_xlate_chk #(
  parameter int unsigned VA_W    = 16,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned FRAME_W = 5,
  localparam int unsigned IDX_W  = VA_W - OFF_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [VA_W-1:0]    vaddr_i,
  input logic [PA_W-1:0]    pa_o,
  input logic               acc_o,
  input logic               fault_o,
  input logic               priv_i,
  input logic               wr_en_i,
  input logic [IDX_W-1:0]   wr_idx_i,
  input logic [FRAME_W-1:0] wr_frame_i,
  input logic               flush_i,
  input logic               priv_viol_o
);
  a_r1_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_o[OFF_W-1:0] == vaddr_i[OFF_W-1:0]);

  a_r4_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && priv_i) |=>
      ((vaddr_i[VA_W-1:OFF_W] != $past(wr_idx_i)) || (pa_o[PA_W-1:OFF_W] == $past(wr_frame_i))));

  a_r5_user_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !priv_i && !flush_i) |=>
      (!$stable(vaddr_i) || ($stable(pa_o) && $stable(acc_o))));

  a_r6_viol_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || flush_i) && !priv_i) |=> priv_viol_o);

  a_r6_viol_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_viol_o |=> priv_viol_o);

  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_o && fault_o));

  a_r8_strobe_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o || fault_o) |-> req_i);
endmodule

bind page_map_xlate page_map_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .vaddr_i     (vaddr_i),
  .pa_o        (pa_o),
  .acc_o       (acc_o),
  .fault_o     (fault_o),
  .priv_i      (priv_i),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_frame_i  (wr_frame_i),
  .flush_i     (flush_i),
  .priv_viol_o (priv_viol_o)
);

// File: tb/tb_page_map_xlate.sv
module tb_page_map_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] vaddr_i = '0;
  logic [17:0] pa_o;
  logic        acc_o, fault_o;
  logic        priv_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [4:0]  wr_frame_i = '0;
  logic        wr_valid_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        priv_viol_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  page_map_xlate dut (.*);

  // {req, vaddr, exp_acc, exp_fault, exp_pa}
  localparam logic [36:0] VEC [8] = '{
    {1'b1, 16'h0000, 1'b1, 1'b0, 18'h04000},
    {1'b1, 16'h3FFF, 1'b1, 1'b0, 18'h0FFFF},
    {1'b1, 16'h4ABC, 1'b1, 1'b0, 18'h18ABC},
    {1'b1, 16'hC123, 1'b0, 1'b1, 18'h00123},
    {1'b0, 16'hC123, 1'b0, 1'b0, 18'h00123},
    {1'b1, 16'hFFFF, 1'b1, 1'b0, 18'h0BFFF},
    {1'b1, 16'hA001, 1'b1, 1'b0, 18'h36001},
    {1'b0, 16'h6000, 1'b0, 1'b0, 18'h22000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [4:0] fr, input logic v, input logic p);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_frame_i = fr; wr_valid_i = v; priv_i = p;
    @(negedge clk_i);
    wr_en_i = 1'b0; priv_i = 1'b0;
  endtask

  task automatic probe(input logic [15:0] va);
    req_i = 1'b1; vaddr_i = va; #1;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    probe(16'h0000);
    chk("R3 viol after reset", 32'(priv_viol_o), 0);
    chk("R3 fault after reset", 32'(fault_o), 1);
    chk("R8 acc on invalid", 32'(acc_o), 0);
    probe(16'hE000);
    chk("R3 frame zero after reset", 32'(pa_o), 32'h0);

    for (int i = 0; i < 8; i++)
      wr(3'(i), 5'((i * 5 + 2) % 32), (i != 6), 1'b1);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      req_i = VEC[i][36]; vaddr_i = VEC[i][35:20]; #1;
      chk($sformatf("R1 R2 pa vec%0d", i), 32'(pa_o), 32'(VEC[i][17:0]));
      chk($sformatf("R7 R8 acc vec%0d", i), 32'(acc_o), 32'(VEC[i][19]));
      chk($sformatf("R7 R8 fault vec%0d", i), 32'(fault_o), 32'(VEC[i][18]));
    end

    // R5 R6: user-mode write rejected
    wr(3'd1, 5'd31, 1'b1, 1'b0);
    probe(16'h2000);
    chk("R5 user write ignored", 32'(pa_o), 32'h0E000);
    chk("R6 viol set", 32'(priv_viol_o), 1);
    repeat (3) @(negedge clk_i);
    chk("R6 viol sticky", 32'(priv_viol_o), 1);

    // R4: write and translate same entry in one cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; priv_i = 1'b1; wr_idx_i = 3'd2; wr_frame_i = 5'd9; wr_valid_i = 1'b1;
    probe(16'h4000);
    chk("R4 old frame same cycle", 32'(pa_o), 32'h18000);
    @(negedge clk_i);
    wr_en_i = 1'b0; priv_i = 1'b0; #1;
    chk("R4 new frame next cycle", 32'(pa_o), 32'h12000);

    // R10: user flush ignored
    @(negedge clk_i);
    flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
    probe(16'h0000);
    chk("R10 user flush keeps valid", 32'(acc_o), 1);

    // R9: privileged flush with concurrent write
    @(negedge clk_i);
    flush_i = 1'b1; priv_i = 1'b1; wr_en_i = 1'b1;
    wr_idx_i = 3'd3; wr_frame_i = 5'd4; wr_valid_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0; priv_i = 1'b0; wr_en_i = 1'b0;
    probe(16'h0000);
    chk("R9 flush clears page0", 32'(fault_o), 1);
    probe(16'h4000);
    chk("R9 flush clears page2", 32'(acc_o), 0);
    probe(16'h6005);
    chk("R9 write beats flush acc", 32'(acc_o), 1);
    chk("R9 write beats flush pa", 32'(pa_o), 32'h08005);

    // R6: only reset clears flag
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1; #1;
    chk("R6 viol cleared by reset", 32'(priv_viol_o), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule